// File: doc/BRIEF.md
# Configurable Four-Input Logic Cell

This block is one configurable logic cell, meant to be tiled into clusters. A 16-bit truth-table word programs a four-input lookup function. An arithmetic mode replaces that function with a one-bit adder or subtractor. A control input shared by the whole cluster picks add or subtract while the design runs. The carry path uses carry-select. The cell takes two incoming carries, one computed under a zero-carry assumption and one under a one-carry assumption. It produces an outgoing carry for each. A separate select input decides which incoming carry feeds the sum bit.

The combinational result is either the lookup value or the sum. It goes straight to the cell outputs without passing through the register, and it also leaves the cell as the chain output to the next cell. The cell has one D flip-flop. Its input comes from the combinational result, from a separate packed-data input, or from the register chain. Each of the three outputs picks either the combinational result or the register on its own. One function and an unrelated register can therefore share the cell. A chain input from the previous cell can take the place of the third lookup input.

Top module: `lut_cell`

## Requirements
- R1: With arith_en_i low, lut_chain_o equals cfg_lut_i[idx], where idx = {d_i[3], d_i[2], d_i[1], d_i[0]} (d_i[0] is the least significant index bit), for any configuration word.
- R2: With use_chain_i high, lut_chain_i takes the place of d_i[2] in the index (bit 2). lut_chain_o always carries the combinational result.
- R3: With arith_en_i high and sub_i low, lut_chain_o = d_i[0] ^ d_i[1] ^ c. Here c is cin1_i when cin_sel_i is 1 and cin0_i when it is 0.
- R4: With sub_i high, d_i[1] is inverted before the sum and carry logic. The sum is then d_i[0] ^ ~d_i[1] ^ c.
- R5: cout0_o = maj(a, b, cin0_i) and cout1_o = maj(a, b, cin1_i), where a = d_i[0] and b is the operand after R4. Neither output depends on cin_sel_i or arith_en_i.
- R6: For each k, out_o[k] is the register output when out_sel_i[k] is 1 and the combinational result when it is 0. Both take effect with no clock edge.
- R7: On each rising clock edge the register loads according to reg_src_i: 0 loads the combinational result, 1 loads pack_d_i, 2 loads reg_chain_i, and 3 holds its value. reg_chain_o shows the register.
- R8: rst_ni low clears the register to 0 at once, without waiting for a clock edge.
- R9: Packing: with reg_src_i = 1, an output selecting the register shows the packed data. Outputs selecting the combinational path keep following an unrelated lookup function.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_lut_i | input | 16 | Truth table of the lookup function |
| d_i | input | 4 | Cell data inputs; d_i[0], d_i[1] are the arithmetic operands |
| use_chain_i | input | 1 | Use lut_chain_i in place of d_i[2] |
| lut_chain_i | input | 1 | Chain input from the previous cell |
| arith_en_i | input | 1 | Arithmetic mode enable |
| sub_i | input | 1 | Cluster-wide subtract select |
| cin0_i | input | 1 | Incoming carry assuming carry 0 |
| cin1_i | input | 1 | Incoming carry assuming carry 1 |
| cin_sel_i | input | 1 | Cluster carry-in select |
| reg_src_i | input | 2 | Register input source code |
| pack_d_i | input | 1 | Packed register data |
| reg_chain_i | input | 1 | Register chain input |
| out_sel_i | input | 3 | Per-output source, 1 = register |
| out_o | output | 3 | Cell outputs |
| lut_chain_o | output | 1 | Combinational result to the next cell |
| reg_chain_o | output | 1 | Register value to the next cell |
| cout0_o | output | 1 | Outgoing carry for carry-in 0 |
| cout1_o | output | 1 | Outgoing carry for carry-in 1 |

## Verification
The lookup, sum, carry and output-select results are combinational. Each one is due in the same cycle as its stimulus. The bench changes these inputs and then samples one time unit later, with no clock edge in between. The register result is due one rising edge after the inputs are set. The bench drives on the falling edge and samples just after the next rising edge. The reset clear is checked one time unit after rst_ni falls, with no edge in between, so a synchronous clear would show up as a failure.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;
  typedef enum logic [1:0] {
    REG_D_COMB  = 2'd0,
    REG_D_PACK  = 2'd1,
    REG_D_CHAIN = 2'd2,
    REG_D_HOLD  = 2'd3
  } reg_src_e;
endpackage

// File: rtl/lut_fn.sv
module lut_fn #(
  parameter int unsigned K = 4,
  localparam int unsigned W = 1 << K
) (
  input  logic [W-1:0] cfg_i,
  input  logic [K-1:0] idx_i,
  output logic         f_o
);
  // mux tree, one level per index bit
  logic [W-1:0] lvl [K+1];
  assign lvl[0] = cfg_i;
  for (genvar s = 0; s < K; s++) begin : g_lvl
    localparam int unsigned N = W >> (s + 1);
    for (genvar j = 0; j < W; j++) begin : g_node
      if (j < N) begin : g_m
        assign lvl[s+1][j] = idx_i[s] ? lvl[s][2*j+1] : lvl[s][2*j];
      end else begin : g_z
        assign lvl[s+1][j] = 1'b0;
      end
    end
  end
  assign f_o = lvl[K][0];
endmodule

// File: rtl/carry_sel.sv
module carry_sel (
  input  logic a_i,
  input  logic b_i,
  input  logic sub_i,
  input  logic cin0_i,
  input  logic cin1_i,
  input  logic cin_sel_i,
  output logic sum_o,
  output logic cout0_o,
  output logic cout1_o
);
  logic b_eff, prop, gen, c_sel;
  assign b_eff   = b_i ^ sub_i;
  assign prop    = a_i ^ b_eff;
  assign gen     = a_i & b_eff;
  // both rails computed; cluster select picks sum carry only
  assign cout0_o = gen | (prop & cin0_i);
  assign cout1_o = gen | (prop & cin1_i);
  assign c_sel   = cin_sel_i ? cin1_i : cin0_i;
  assign sum_o   = prop ^ c_sel;
endmodule

// File: rtl/cell_reg.sv
module cell_reg
  import lut_cell_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  reg_src_e src_i,
  input  logic     comb_i,
  input  logic     pack_i,
  input  logic     chain_i,
  output logic     q_o
);
  logic d;
  always_comb begin
    unique case (src_i)
      REG_D_COMB:  d = comb_i;
      REG_D_PACK:  d = pack_i;
      REG_D_CHAIN: d = chain_i;
      default:     d = q_o;
    endcase
  end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d;
  end
endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_cell_pkg::*;
#(
  parameter int unsigned K         = 4,
  parameter int unsigned NUM_OUT   = 3,
  parameter int unsigned CHAIN_BIT = 2,
  localparam int unsigned LUT_W    = 1 << K
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LUT_W-1:0]   cfg_lut_i,
  input  logic [K-1:0]       d_i,
  input  logic               use_chain_i,
  input  logic               lut_chain_i,
  input  logic               arith_en_i,
  input  logic               sub_i,
  input  logic               cin0_i,
  input  logic               cin1_i,
  input  logic               cin_sel_i,
  input  logic [1:0]         reg_src_i,
  input  logic               pack_d_i,
  input  logic               reg_chain_i,
  input  logic [NUM_OUT-1:0] out_sel_i,
  output logic [NUM_OUT-1:0] out_o,
  output logic               lut_chain_o,
  output logic               reg_chain_o,
  output logic               cout0_o,
  output logic               cout1_o
);
  logic [K-1:0] idx;
  logic         lut_f, sum, comb, q;

  always_comb begin
    idx = d_i;
    if (use_chain_i) idx[CHAIN_BIT] = lut_chain_i;
  end

  lut_fn #(.K(K)) u_lut (
    .cfg_i (cfg_lut_i),
    .idx_i (idx),
    .f_o   (lut_f)
  );

  carry_sel u_arith (
    .a_i       (d_i[0]),
    .b_i       (d_i[1]),
    .sub_i     (sub_i),
    .cin0_i    (cin0_i),
    .cin1_i    (cin1_i),
    .cin_sel_i (cin_sel_i),
    .sum_o     (sum),
    .cout0_o   (cout0_o),
    .cout1_o   (cout1_o)
  );

  assign comb = arith_en_i ? sum : lut_f;

  cell_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (reg_src_e'(reg_src_i)),
    .comb_i  (comb),
    .pack_i  (pack_d_i),
    .chain_i (reg_chain_i),
    .q_o     (q)
  );

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    assign out_o[k] = out_sel_i[k] ? q : comb;
  end

  assign lut_chain_o = comb;
  assign reg_chain_o = q;
endmodule

// File: rtl/lut_cell_chk.sv
module lut_cell_chk #(
  parameter int unsigned K       = 4,
  parameter int unsigned NUM_OUT = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [K-1:0]       d_i,
  input logic               arith_en_i,
  input logic               sub_i,
  input logic               cin0_i,
  input logic               cin1_i,
  input logic               cin_sel_i,
  input logic [1:0]         reg_src_i,
  input logic               pack_d_i,
  input logic               reg_chain_i,
  input logic [NUM_OUT-1:0] out_sel_i,
  input logic [NUM_OUT-1:0] out_o,
  input logic               lut_chain_o,
  input logic               reg_chain_o,
  input logic               cout0_o,
  input logic               cout1_o
);
  AST_ADD_NO_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arith_en_i && !sub_i && !cin_sel_i && !cin0_i) |-> (lut_chain_o == (d_i[0] ^ d_i[1]))); // R3
  AST_SUB_INVERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arith_en_i && sub_i && !cin_sel_i && !cin0_i) |-> (lut_chain_o == (d_i[0] ^ ~d_i[1]))); // R4
  AST_COUT_MONOTONIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cin0_i && cin1_i) |-> (!cout0_o || cout1_o)); // R5
  AST_COUT_EQUAL_CIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cin0_i == cin1_i) |-> (cout0_o == cout1_o)); // R5
  AST_OUT_REG_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((out_sel_i & (out_o ^ {NUM_OUT{reg_chain_o}})) == '0)); // R6
  AST_OUT_COMB_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~out_sel_i & (out_o ^ {NUM_OUT{lut_chain_o}})) == '0)); // R6
  AST_REG_PACK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_src_i == 2'd1) |=> (reg_chain_o == $past(pack_d_i))); // R9
  AST_REG_CHAIN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_src_i == 2'd2) |=> (reg_chain_o == $past(reg_chain_i))); // R7
  AST_REG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_src_i == 2'd3) |=> $stable(reg_chain_o)); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (reg_chain_o == 1'b0)); // R8
endmodule

bind lut_cell lut_cell_chk #(.K(K), .NUM_OUT(NUM_OUT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .d_i         (d_i),
  .arith_en_i  (arith_en_i),
  .sub_i       (sub_i),
  .cin0_i      (cin0_i),
  .cin1_i      (cin1_i),
  .cin_sel_i   (cin_sel_i),
  .reg_src_i   (reg_src_i),
  .pack_d_i    (pack_d_i),
  .reg_chain_i (reg_chain_i),
  .out_sel_i   (out_sel_i),
  .out_o       (out_o),
  .lut_chain_o (lut_chain_o),
  .reg_chain_o (reg_chain_o),
  .cout0_o     (cout0_o),
  .cout1_o     (cout1_o)
);

// File: tb/tb_lut_cell.sv
module tb_lut_cell;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [15:0] cfg_lut_i;
  logic [3:0]  d_i;
  logic        use_chain_i, lut_chain_i, arith_en_i, sub_i;
  logic        cin0_i, cin1_i, cin_sel_i;
  logic [1:0]  reg_src_i;
  logic        pack_d_i, reg_chain_i;
  logic [2:0]  out_sel_i;
  logic [2:0]  out_o;
  logic        lut_chain_o, reg_chain_o, cout0_o, cout1_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lut_cell dut (
    .clk_i, .rst_ni, .cfg_lut_i, .d_i, .use_chain_i, .lut_chain_i,
    .arith_en_i, .sub_i, .cin0_i, .cin1_i, .cin_sel_i, .reg_src_i,
    .pack_d_i, .reg_chain_i, .out_sel_i, .out_o, .lut_chain_o,
    .reg_chain_o, .cout0_o, .cout1_o
  );

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic maj(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  task automatic idle();
    cfg_lut_i = 16'h0000; d_i = 4'h0; use_chain_i = 0; lut_chain_i = 0;
    arith_en_i = 0; sub_i = 0; cin0_i = 0; cin1_i = 0; cin_sel_i = 0;
    reg_src_i = 2'd3; pack_d_i = 0; reg_chain_i = 0; out_sel_i = 3'b000;
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    check("R8 reset state", {2'b00, reg_chain_o}, 3'b000);
  endtask

  task automatic t_lut_all();
    logic [15:0] cfgs [4] = '{16'h8000, 16'h6996, 16'hA5C3, 16'h0001};
    @(negedge clk_i);
    foreach (cfgs[c]) begin
      cfg_lut_i = cfgs[c];
      for (int i = 0; i < 16; i++) begin
        d_i = 4'(i);
        #1;
        check("R1 lut lookup", {2'b00, lut_chain_o}, {2'b00, cfgs[c][i]});
      end
    end
  endtask

  task automatic t_chain();
    @(negedge clk_i);
    cfg_lut_i = 16'h00F0;       // 1 only when index bit 2 set, bit 3 clear
    use_chain_i = 1;
    for (int i = 0; i < 8; i++) begin
      d_i = {1'b0, 3'(i)};
      for (int l = 0; l < 2; l++) begin
        lut_chain_i = 1'(l);
        #1;
        check("R2 chain replaces d2", {2'b00, lut_chain_o}, {2'b00, 1'(l)});
      end
    end
    use_chain_i = 0;
  endtask

  task automatic t_arith(input logic sub);
    @(negedge clk_i);
    cfg_lut_i = 16'hFFFF;       // must be overridden by the sum
    arith_en_i = 1; sub_i = sub;
    for (int i = 0; i < 32; i++) begin
      logic a, b, c0, c1, cs, be, c;
      {a, b, c0, c1, cs} = 5'(i);
      d_i = {2'b00, b, a};
      cin0_i = c0; cin1_i = c1; cin_sel_i = cs;
      #1;
      be = b ^ sub;
      c = cs ? c1 : c0;
      check(sub ? "R4 subtract sum" : "R3 add sum", {2'b00, lut_chain_o}, {2'b00, a ^ be ^ c});
      check("R5 carry rails", {1'b0, cout1_o, cout0_o}, {1'b0, maj(a, be, c1), maj(a, be, c0)});
    end
    // carries unaffected by arithmetic enable
    arith_en_i = 0; d_i = 4'b0011; cin0_i = 0; cin1_i = 1; sub_i = 0;
    #1;
    check("R5 carry without arith", {1'b0, cout1_o, cout0_o}, 3'b011);
    arith_en_i = 0; sub_i = 0;
  endtask

  task automatic t_reg();
    @(negedge clk_i);
    cfg_lut_i = 16'hFFFF; reg_src_i = 2'd0;
    @(posedge clk_i); #1;
    check("R7 load comb", {2'b00, reg_chain_o}, 3'b001);
    @(negedge clk_i);
    reg_src_i = 2'd2; reg_chain_i = 0;
    @(posedge clk_i); #1;
    check("R7 load chain", {2'b00, reg_chain_o}, 3'b000);
    @(negedge clk_i);
    reg_src_i = 2'd3; pack_d_i = 1; reg_chain_i = 1;
    @(posedge clk_i); #1;
    check("R7 hold", {2'b00, reg_chain_o}, 3'b000);
    @(negedge clk_i);
    reg_src_i = 2'd2;
    @(posedge clk_i); #1;
    check("R7 load chain one", {2'b00, reg_chain_o}, 3'b001);
    @(negedge clk_i);
    reg_src_i = 2'd3;
  endtask

  task automatic t_out_sel();
    @(negedge clk_i);
    pack_d_i = 1; reg_src_i = 2'd1;
    @(posedge clk_i); #1;
    @(negedge clk_i);
    reg_src_i = 2'd3; cfg_lut_i = 16'h0000;
    for (int s = 0; s < 8; s++) begin
      out_sel_i = 3'(s);
      #1;
      check("R6 output select", out_o, 3'(s));
    end
    out_sel_i = 3'b000;
  endtask

  task automatic t_pack();
    @(negedge clk_i);
    cfg_lut_i = 16'h8000; d_i = 4'hF; pack_d_i = 0; reg_src_i = 2'd1;
    out_sel_i = 3'b010;
    @(posedge clk_i); #1;
    check("R9 packed reg with lut", out_o, 3'b101);
    @(negedge clk_i);
    reg_src_i = 2'd3; d_i = 4'h7;
    #1;
    check("R9 lut moves reg stays", out_o, 3'b000);
    @(negedge clk_i);
    reg_src_i = 2'd1; pack_d_i = 1; d_i = 4'hF;
    @(posedge clk_i); #1;
    check("R9 packed reg one", out_o, 3'b111);
    @(negedge clk_i);
    reg_src_i = 2'd3; out_sel_i = 3'b000;
  endtask

  task automatic t_async_reset();
    @(negedge clk_i);
    check("R8 preset before reset", {2'b00, reg_chain_o}, 3'b001);
    #2 rst_ni = 0;
    #1;
    check("R8 async clear", {2'b00, reg_chain_o}, 3'b000);
    @(negedge clk_i);
    rst_ni = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst_ni = 0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    t_lut_all();
    t_chain();
    t_arith(1'b0);
    t_arith(1'b1);
    t_reg();
    t_out_sel();
    t_pack();
    t_async_reset();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule